// File: doc/BRIEF.md
# GPIO Bank with Set/Clear Register Aliases

This block holds the software-visible configuration of one bank of up to 32 general-purpose pins. Software reaches it through a plain memory-mapped bus: a write strobe with a byte address and a 32-bit word, and a separate read address that returns a 32-bit word in the same cycle. Every control register has three write views. The base address replaces the word. One alias turns on the bits that are 1 in the written word. A second alias turns off the bits that are 1 in the written word. Software can therefore change one pin without a read-modify-write sequence.

The bank drives output data and output enable for each pin, presents a pull-up enable for each pin, and passes on an interrupt mask word and a trigger word for interrupt logic outside the block. It also decodes which function owns each pin: plain GPIO or one of three alternate functions. The choice comes from three bits per pin (function, select, trigger). The pad inputs go through a synchronizer before software can read them. A bank can be built with fewer than 32 pins. The bits for missing pins read as zero, drive zero and ignore writes.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous active-low reset, every control register is zero except the interrupt mask, which is all ones on the implemented pins. Every pin is therefore a GPIO input with its pull-up enabled.
- R2: Base offsets (the low two address bits are ignored): output data 0x10, interrupt mask 0x20, pull 0x30, function 0x40, select 0x50, direction 0x60, trigger 0x70. A write to a base offset replaces the register. The new value shows on the read port and on the outputs from the next cycle.
- R3: A write to base+4 ORs the 1-bits of the word into the register and leaves the other bits unchanged.
- R4: A write to base+8 clears the register bits that are 1 in the word and leaves the other bits unchanged.
- R5: Each implemented pin is in exactly one function. Function bit 0 gives plain GPIO. Function 1 with select 0 gives alternate 1, whatever the trigger bit is. Function 1, select 1 and trigger 0 give alternate 2. All three bits at 1 give alternate 3.
- R6: `pin_oe` equals the direction register (1 means output) and `pin_out` equals the output data register.
- R7: The pull register is active-low: `pull_en` is 1 exactly where the pull bit is 0.
- R8: With NUM_PINS below 32, the bits above NUM_PINS-1 read as zero on every offset, drive zero on every output and ignore writes.
- R9: Offset 0x00 reads the pin inputs through a SYNC_STAGES-flop synchronizer. With the default of 2, a change on `pin_in` just before a clock edge becomes readable after the second edge.
- R10: Reads of +4, +8 and +0xC offsets, and of offsets from 0x80 upward, return zero. Writes to offset 0x00, to +0xC offsets and to offsets from 0x80 upward change nothing.
- R11: A read in the same cycle as a write to the same register returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one word |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write word |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read word, combinational from rd_addr |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Output data for each pin |
| pin_oe | output | 32 | Output enable for each pin |
| pull_en | output | 32 | Pull-up enable for each pin, active high |
| irq_mask | output | 32 | Interrupt mask word for the external interrupt logic |
| trig_cfg | output | 32 | Trigger word for the external interrupt logic |
| fn_gpio | output | 32 | Pin in plain GPIO function |
| fn_alt1 | output | 32 | Pin in alternate function 1 |
| fn_alt2 | output | 32 | Pin in alternate function 2 |
| fn_alt3 | output | 32 | Pin in alternate function 3 |

## Verification
Two things can meet in one cycle: a write that changes a register, and a read of that same register on the independent read port. The bench provokes this by putting a set-alias write to output data and a base read of output data in the same cycle. It expects the old word during that cycle and the updated word one cycle later. A second meeting happens between the input synchronizer and a read of offset 0x00 while the pads change. The bench holds a read of that offset across the pad change and compares the result cycle by cycle with a behavioural reference model, so any extra or missing stage shows up.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants and types for the GPIO bank.
// Assumes a fixed 32-bit bank word; the address layout puts the register
// slot in bits [6:4] and the access kind in bits [3:2].
package gpio_bank_pkg;

    localparam int BANK_W  = 32;
    localparam int NUM_CTL = 7;

    // Access kind carried in address bits [3:2]
    typedef enum logic [1:0] {
        ACC_BASE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_NONE = 2'd3
    } acc_kind_t;

    // Register slot carried in address bits [6:4]
    typedef enum logic [2:0] {
        SLOT_LEVEL = 3'd0,
        SLOT_DATA  = 3'd1,
        SLOT_MASK  = 3'd2,
        SLOT_PULL  = 3'd3,
        SLOT_FUNC  = 3'd4,
        SLOT_SEL   = 3'd5,
        SLOT_DIR   = 3'd6,
        SLOT_TRIG  = 3'd7
    } slot_t;

endpackage

// File: rtl/gpio_ctl_reg.sv
// Module: one control word with replace, OR-in and clear-out write views.
// Assumes the caller decodes which register is addressed and passes a
// single hit strobe; IMPL marks the bits that physically exist.
module gpio_ctl_reg
    import gpio_bank_pkg::*;
#(
    parameter int              WIDTH   = 32,
    parameter logic [WIDTH-1:0] RST_VAL = '0,
    parameter logic [WIDTH-1:0] IMPL    = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  acc_kind_t        kind,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] RST_EFF = RST_VAL & IMPL;

    // Update the word according to the access kind on an addressed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_EFF;
        end else if (hit) begin
            case (kind)
                ACC_BASE: q <= wdata & IMPL;
                ACC_SET:  q <= q | (wdata & IMPL);
                ACC_CLR:  q <= q & ~wdata;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-flop synchronizer for the pad input levels.
// Assumes STAGES >= 1; all stages reset to zero.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift the pad levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_func_decode.sv
// Module: turns the function, select and trigger bits of each pin into a
// one-hot choice among GPIO and three alternate functions.
// Assumes unimplemented pins are flagged by IMPL and must show no function.
module gpio_func_decode #(
    parameter int              WIDTH = 32,
    parameter logic [WIDTH-1:0] IMPL  = '1
) (
    input  logic [WIDTH-1:0] func_q,
    input  logic [WIDTH-1:0] sel_q,
    input  logic [WIDTH-1:0] trig_q,
    output logic [WIDTH-1:0] is_gpio,
    output logic [WIDTH-1:0] is_alt1,
    output logic [WIDTH-1:0] is_alt2,
    output logic [WIDTH-1:0] is_alt3
);

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        if (IMPL[p]) begin : g_live
            // Decode the three configuration bits of this pin
            always_comb begin
                is_gpio[p] = ~func_q[p];
                is_alt1[p] =  func_q[p] & ~sel_q[p];
                is_alt2[p] =  func_q[p] &  sel_q[p] & ~trig_q[p];
                is_alt3[p] =  func_q[p] &  sel_q[p] &  trig_q[p];
            end
        end else begin : g_absent
            // A missing pin owns no function
            always_comb begin
                is_gpio[p] = 1'b0;
                is_alt1[p] = 1'b0;
                is_alt2[p] = 1'b0;
                is_alt3[p] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/gpio_bank.sv
// Module: GPIO bank top. Decodes the write and read ports, holds the seven
// control words, synchronizes the pad levels and drives the pin outputs.
// Assumes ADDR_W >= 8; addresses with any bit at or above bit 7 set are
// unmapped; the low two address bits are ignored.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 31,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_oe,
    output logic [31:0]       pull_en,
    output logic [31:0]       irq_mask,
    output logic [31:0]       trig_cfg,
    output logic [31:0]       fn_gpio,
    output logic [31:0]       fn_alt1,
    output logic [31:0]       fn_alt2,
    output logic [31:0]       fn_alt3
);

    localparam logic [BANK_W-1:0] IMPL_MASK = {BANK_W{1'b1}} >> (BANK_W - NUM_PINS);

    logic [BANK_W-1:0] ctl_q [0:NUM_CTL];
    logic [NUM_CTL:1]  wr_hit;
    logic              wr_map, rd_map;
    slot_t             wr_slot, rd_slot;
    acc_kind_t         wr_kind, rd_kind;
    logic [BANK_W-1:0] lvl_sync;
    logic [3:0]        unused_addr_lsb;

    assign unused_addr_lsb = {wr_addr[1:0], rd_addr[1:0]};

    assign wr_map  = (wr_addr[ADDR_W-1:7] == '0);
    assign rd_map  = (rd_addr[ADDR_W-1:7] == '0);
    assign wr_slot = slot_t'(wr_addr[6:4]);
    assign rd_slot = slot_t'(rd_addr[6:4]);
    assign wr_kind = acc_kind_t'(wr_addr[3:2]);
    assign rd_kind = acc_kind_t'(rd_addr[3:2]);

    // One strobe per control word; the level slot never takes writes
    always_comb begin
        for (int k = 1; k <= NUM_CTL; k++) begin
            wr_hit[k] = wr_en && wr_map && (int'(wr_slot) == k);
        end
    end

    for (genvar k = 1; k <= NUM_CTL; k++) begin : g_ctl
        localparam logic [BANK_W-1:0] RV = (k == int'(SLOT_MASK)) ? IMPL_MASK : '0;
        gpio_ctl_reg #(
            .WIDTH   (BANK_W),
            .RST_VAL (RV),
            .IMPL    (IMPL_MASK)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (wr_hit[k]),
            .kind  (wr_kind),
            .wdata (wr_data),
            .q     (ctl_q[k])
        );
    end

    gpio_in_sync #(
        .WIDTH  (BANK_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (lvl_sync)
    );

    assign ctl_q[0] = lvl_sync & IMPL_MASK;

    // Only base offsets inside the mapped window return data
    always_comb begin
        if (rd_map && rd_kind == ACC_BASE) rd_data = ctl_q[rd_slot];
        else                               rd_data = '0;
    end

    assign pin_out  = ctl_q[SLOT_DATA];
    assign pin_oe   = ctl_q[SLOT_DIR];
    assign pull_en  = ~ctl_q[SLOT_PULL] & IMPL_MASK;
    assign irq_mask = ctl_q[SLOT_MASK];
    assign trig_cfg = ctl_q[SLOT_TRIG];

    gpio_func_decode #(
        .WIDTH (BANK_W),
        .IMPL  (IMPL_MASK)
    ) u_dec (
        .func_q  (ctl_q[SLOT_FUNC]),
        .sel_q   (ctl_q[SLOT_SEL]),
        .trig_q  (ctl_q[SLOT_TRIG]),
        .is_gpio (fn_gpio),
        .is_alt1 (fn_alt1),
        .is_alt2 (fn_alt2),
        .is_alt3 (fn_alt3)
    );

endmodule

// File: rtl/gpio_bank_chk.sv
// Module: property checker for the GPIO bank, bound to every instance.
// Assumes it sees only the ports of the bank.
module gpio_bank_chk #(
    parameter int NUM_PINS = 31,
    parameter int ADDR_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic [31:0]       pin_out,
    input logic [31:0]       pin_oe,
    input logic [31:0]       pull_en,
    input logic [31:0]       irq_mask,
    input logic [31:0]       fn_gpio,
    input logic [31:0]       fn_alt1,
    input logic [31:0]       fn_alt2,
    input logic [31:0]       fn_alt3
);

    localparam logic [31:0] IMPL = {32{1'b1}} >> (32 - NUM_PINS);

    logic was_rst;

    // Remember that the previous edge was a reset edge
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (irq_mask == IMPL && pin_oe == '0 && pin_out == '0 && pull_en == IMPL));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pin_out) && $stable(pin_oe) && $stable(irq_mask)));

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(8'h14)) |=>
            ((pin_out & $past(wr_data & IMPL)) == $past(wr_data & IMPL)
             && (pin_out & $past(~wr_data)) == ($past(pin_out) & $past(~wr_data))));

    // R4
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(8'h18)) |=> ((pin_out & $past(wr_data)) == '0));

    // R5
    one_function_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fn_gpio | fn_alt1 | fn_alt2 | fn_alt3) == IMPL)
        && ((fn_gpio & fn_alt1) | (fn_gpio & fn_alt2) | (fn_gpio & fn_alt3)
            | (fn_alt1 & fn_alt2) | (fn_alt1 & fn_alt3) | (fn_alt2 & fn_alt3)) == '0);

    // R8
    absent_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out | pin_oe | pull_en | irq_mask | rd_data) & ~IMPL) == '0);

    // R10
    alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[3:2] != 2'b00 || rd_addr[ADDR_W-1:7] != '0) |-> rd_data == '0);

endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pull_en  (pull_en),
    .irq_mask (irq_mask),
    .fn_gpio  (fn_gpio),
    .fn_alt1  (fn_alt1),
    .fn_alt2  (fn_alt2),
    .fn_alt3  (fn_alt3)
);

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;

    localparam int NP   = 31;
    localparam int SYNC = 2;
    localparam logic [31:0] IMPL = 32'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pull_en, irq_mask, trig_cfg;
    logic [31:0] fn_gpio, fn_alt1, fn_alt2, fn_alt3;

    int n_chk = 0;
    int n_err = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    gpio_bank #(.NUM_PINS(NP), .ADDR_W(8), .SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_en(pull_en), .irq_mask(irq_mask), .trig_cfg(trig_cfg),
        .fn_gpio(fn_gpio), .fn_alt1(fn_alt1), .fn_alt2(fn_alt2), .fn_alt3(fn_alt3)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    // Behavioural reference model: word per slot, queue of sampled pads
    logic [31:0] mreg [8];
    logic [31:0] lvl_q [$];

    function automatic logic [31:0] m_level();
        return (lvl_q.size() >= SYNC) ? (lvl_q[0] & IMPL) : 32'h0;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a[7] || a[3:2] != 2'b00) return 32'h0;
        if (a[6:4] == 3'd0) return m_level();
        return mreg[a[6:4]];
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mreg[i] = 32'h0;
            mreg[2] = IMPL;
            lvl_q.delete();
        end else begin
            if (wr_en && !wr_addr[7] && wr_addr[6:4] != 3'd0) begin
                case (wr_addr[3:2])
                    2'd0: mreg[wr_addr[6:4]] = wr_data & IMPL;
                    2'd1: mreg[wr_addr[6:4]] = mreg[wr_addr[6:4]] | (wr_data & IMPL);
                    2'd2: mreg[wr_addr[6:4]] = mreg[wr_addr[6:4]] & ~wr_data;
                    default: ;
                endcase
            end
            lvl_q.push_back(pin_in);
            if (lvl_q.size() > SYNC) void'(lvl_q.pop_front());
        end
    end

    // Compare every output with the model shortly after each edge
    always @(posedge clk) begin
        #1;
        if (started) begin
            logic [31:0] f, s, t;
            f = mreg[4]; s = mreg[5]; t = mreg[7];
            chk("R2 rd_data", rd_data, m_read(rd_addr));
            chk("R6 pin_out", pin_out, mreg[1]);
            chk("R6 pin_oe", pin_oe, mreg[6]);
            chk("R7 pull_en", pull_en, ~mreg[3] & IMPL);
            chk("R2 irq_mask", irq_mask, mreg[2]);
            chk("R2 trig_cfg", trig_cfg, mreg[7]);
            chk("R5 fn_gpio", fn_gpio, ~f & IMPL);
            chk("R5 fn_alt1", fn_alt1, f & ~s);
            chk("R5 fn_alt2", fn_alt2, f & s & ~t);
            chk("R5 fn_alt3", fn_alt3, f & s & t);
        end
    end

    task automatic do_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 mask reset", 8'h20, IMPL);
        rd_chk("R1 data reset", 8'h10, 32'h0);
        chk("R1 pull_en reset", pull_en, IMPL);
        chk("R1 pin_oe reset", pin_oe, 32'h0);
        // R2 / R8 base write, top bit absent
        do_wr(8'h10, 32'hFFFF_FFFF);
        rd_chk("R2 R8 data replace", 8'h10, 32'h7FFF_FFFF);
        chk("R8 pin_out top bit", pin_out, 32'h7FFF_FFFF);
        // R4 clear alias
        do_wr(8'h18, 32'h0000_00F0);
        rd_chk("R4 clear alias", 8'h10, 32'h7FFF_FF0F);
        // R3 set alias
        do_wr(8'h10, 32'h0);
        do_wr(8'h14, 32'h0000_0005);
        do_wr(8'h14, 32'h0000_0100);
        rd_chk("R3 set alias", 8'h10, 32'h0000_0105);
        // R5 function decode: pins 0..3
        do_wr(8'h40, 32'hF);
        do_wr(8'h50, 32'h6);
        do_wr(8'h70, 32'hC);
        chk("R5 alt1", fn_alt1, 32'h9);
        chk("R5 alt2", fn_alt2, 32'h2);
        chk("R5 alt3", fn_alt3, 32'h4);
        chk("R5 gpio", fn_gpio, 32'h7FFF_FFF0);
        // R6 direction
        do_wr(8'h64, 32'h3);
        chk("R6 pin_oe", pin_oe, 32'h3);
        // R7 / R8 pull active low
        do_wr(8'h34, 32'h8000_0001);
        rd_chk("R8 pull absent bit", 8'h30, 32'h1);
        chk("R7 pull_en", pull_en, 32'h7FFF_FFFE);
        // R9 synchronizer latency
        @(negedge clk);
        pin_in = 32'hA5A5_A5A5;
        rd_addr = 8'h00;
        @(negedge clk);
        #1 chk("R9 one edge", rd_data, 32'h0);
        @(negedge clk);
        #1 chk("R9 two edges", rd_data, 32'h25A5_A5A5);
        // R10 alias and unmapped reads, ignored writes
        rd_chk("R10 set alias read", 8'h14, 32'h0);
        rd_chk("R10 clear alias read", 8'h58, 32'h0);
        rd_chk("R10 hole read", 8'h1C, 32'h0);
        rd_chk("R10 unmapped read", 8'h90, 32'h0);
        do_wr(8'h00, 32'hFFFF_FFFF);
        do_wr(8'h1C, 32'hFFFF_FFFF);
        do_wr(8'h90, 32'hFFFF_FFFF);
        rd_chk("R10 level untouched", 8'h00, 32'h25A5_A5A5);
        rd_chk("R10 data untouched", 8'h10, 32'h0000_0105);
        chk("R10 mask untouched", irq_mask, IMPL);
        // R11 same-cycle write and read
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h14; wr_data = 32'h0001_0000;
        rd_addr = 8'h10;
        #1 chk("R11 old value", rd_data, 32'h0000_0105);
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R11 new value", rd_data, 32'h0001_0105);
        // Mixed traffic with moving pads, model compared every cycle
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            pin_in = pin_in * 32'd1103515245 + 32'd12345;
            wr_en = (i % 3) != 0;
            wr_addr = {1'b0, 3'(i * 5), 2'(i), 2'b00};
            wr_data = pin_in ^ 32'h5A5A_0F0F;
            rd_addr = {1'b0, 3'(i * 3), 2'(i / 4), 2'b00};
        end
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule